// File: doc/BRIEF.md
# Keyed Flash Program/Erase Sequencer

This block is the write side of an embedded flash. Software sets up registers over a simple write bus: the operation code and a write-enable bit, a physical target address, four data words, and a source address in system memory. It then writes a start bit. The start bit only takes effect if three key writes come directly before it, so a stray store cannot launch an erase or a program. While an operation runs, the start bit reads back as a busy flag. Hardware clears it when the operation ends. Two sticky flags report a failed operation: one for write errors and one for low voltage.

The flash itself is a behavioural word array. Erase sets words to all ones, and programming can only clear bits. Each kind of operation has its own cycle-count parameter that sets how long it takes. Row programming fetches its data one word per cycle through a combinational memory read port. A separate read port exposes the array, and a read select returns any register.

Top module: `fpe_ctrl`

## Requirements
- R1: Register selects are 0 control, 1 key, 2 target, 3 source, and 4 to 7 data words 0 to 3. The control register has these fields: bits [2:0] operation code, bit 4 write-enable, bit 12 low-voltage error, bit 13 write error, bit 15 start/busy. Key writes of 0x00000000, 0xAA996655 and 0x556699AA, in that order, followed directly by a control write with bit 15 set, start the operation when write-enable is 1 and no operation is running.
- R2: A start is ignored if the key order was broken, or if any non-key write came between the last key and the start. Busy stays 0, the flags do not change and the array does not change.
- R3: An unlocked start is refused if write-enable is 0 or the operation code is 5 or 6. Busy stays 0, the write-error flag is set one cycle later, and the array does not change.
- R4: Busy stays high for a fixed number of cycles that depends on the operation: 1 for code 0 (no operation), PROG_CYC for codes 1 and 2, ROW_WORDS plus ROW_CYC for code 3, ERASE_CYC for code 4 and AREA_CYC for code 7.
- R5: Code 1 programs data words 0 and 1 into the two-word pair that contains the target address. The low three address bits are ignored.
- R6: Code 2 programs data words 0 to 3 into the four-word group that contains the target address. The low four address bits are ignored.
- R7: Code 3 programs ROW_WORDS words into the row that contains the target address. Word i comes from the memory port at the source address plus 4*i.
- R8: Code 4 sets every word of the target's page to all ones and leaves other pages unchanged. Code 7 sets the whole array to all ones.
- R9: Programming stores the old value AND the data. If any programmed word needs a 0 turned back into a 1, the write-error flag is set.
- R10: While busy is 1, writes to the target, source and data registers and to the control fields are ignored.
- R11: The low-voltage flag is set if the low-voltage input is high during an operation. An accepted start clears both flags. A control write with bit 15 at 0, made while idle, loads both flags from bits 13 and 12.
- R12: After reset, the array reads all ones and every control field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select for writes |
| bus_wdata | input | 32 | Write data |
| bus_rsel | input | 3 | Register select for reads |
| bus_rdata | output | 32 | Selected register value |
| mem_addr | output | MEM_AW | Byte address of the row source word |
| mem_rdata | input | 32 | Source word, valid in the same cycle |
| lowv_i | input | 1 | Low-voltage indication |
| arr_ridx | input | ADDR_W-2 | Array word index to read |
| arr_rdata | output | 32 | Array word |

## Verification
A start write that is accepted raises busy on the next edge. Busy then stays high for exactly the duration of the operation, so the bench counts the falling edges on which the busy bit reads 1 and compares the count with the figure in R4. A refused or ignored start shows its result at the first falling edge after the start edge: busy reads 0, and the write-error flag reads 1 for a refusal and is unchanged for an ignored start. Array contents and register values are read only after busy has fallen, when all updates are complete.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_KEY  = 3'd1;
  localparam logic [2:0] SEL_TGT  = 3'd2;
  localparam logic [2:0] SEL_SRC  = 3'd3;
  localparam logic [2:0] SEL_DAT0 = 3'd4;

  localparam int CB_WREN  = 4;
  localparam int CB_LVERR = 12;
  localparam int CB_WRERR = 13;
  localparam int CB_GO    = 15;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0000;
  localparam logic [31:0] KEY_SECOND = 32'hAA99_6655;
  localparam logic [31:0] KEY_THIRD  = 32'h5566_99AA;

  localparam logic [2:0] OP_NONE    = 3'd0;
  localparam logic [2:0] OP_DWORD   = 3'd1;
  localparam logic [2:0] OP_QWORD   = 3'd2;
  localparam logic [2:0] OP_ROW     = 3'd3;
  localparam logic [2:0] OP_PAGE_ER = 3'd4;
  localparam logic [2:0] OP_AREA_ER = 3'd7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_WAIT} sq_state_e;

  function automatic logic op_known(input logic [2:0] op);
    return (op != 3'd5) && (op != 3'd6);
  endfunction
endpackage

// File: rtl/fpe_unlock.sv
module fpe_unlock
  import fpe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        other_wr,
  output logic        unlocked
);
  logic [1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (other_wr) begin
      stage_d = 2'd0;
    end else if (key_wr) begin
      case (stage_q)
        2'd0:    stage_d = (key_data == KEY_FIRST)  ? 2'd1 : 2'd0;
        2'd1:    stage_d = (key_data == KEY_SECOND) ? 2'd2 : 2'd0;
        2'd2:    stage_d = (key_data == KEY_THIRD)  ? 2'd3 : 2'd0;
        default: stage_d = 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'd0;
    else if (key_wr || other_wr) stage_q <= stage_d;
  end

  assign unlocked = (stage_q == 2'd3);
endmodule

// File: rtl/fpe_regs.sv
module fpe_regs
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_sel,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bus_rsel,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              clr_err,
  input  logic              set_wrerr,
  input  logic              set_lverr,
  output logic              key_wr,
  output logic              other_wr,
  output logic              start_wr,
  output logic [2:0]        op,
  output logic              wren,
  output logic              wrerr,
  output logic              lverr,
  output logic [ADDR_W-1:0] tgt,
  output logic [MEM_AW-1:0] src,
  output logic [3:0][31:0]  dat
);
  logic ctrl_wr, plain_wr, cfg_en;
  logic wrerr_d, lverr_d;

  assign ctrl_wr  = bus_we && (bus_sel == SEL_CTRL);
  assign start_wr = ctrl_wr && bus_wdata[CB_GO];
  assign plain_wr = ctrl_wr && !bus_wdata[CB_GO] && !busy;
  assign key_wr   = bus_we && (bus_sel == SEL_KEY);
  assign other_wr = bus_we && (bus_sel != SEL_KEY);
  assign cfg_en   = bus_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op   <= OP_NONE;
      wren <= 1'b0;
    end else if (plain_wr) begin
      op   <= bus_wdata[2:0];
      wren <= bus_wdata[CB_WREN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt <= '0;
    else if (cfg_en && (bus_sel == SEL_TGT)) tgt <= bus_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src <= '0;
    else if (cfg_en && (bus_sel == SEL_SRC)) src <= bus_wdata[MEM_AW-1:0];
  end

  for (genvar k = 0; k < 4; k++) begin : g_dat
    localparam logic [2:0] SK = SEL_DAT0 + 3'(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dat[k] <= '0;
      else if (cfg_en && (bus_sel == SK)) dat[k] <= bus_wdata;
    end
  end

  always_comb begin
    wrerr_d = wrerr;
    lverr_d = lverr;
    if (plain_wr) begin
      wrerr_d = bus_wdata[CB_WRERR];
      lverr_d = bus_wdata[CB_LVERR];
    end
    if (clr_err) begin
      wrerr_d = 1'b0;
      lverr_d = 1'b0;
    end
    if (set_wrerr) wrerr_d = 1'b1;
    if (set_lverr) lverr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrerr <= 1'b0;
      lverr <= 1'b0;
    end else if (plain_wr || clr_err || set_wrerr || set_lverr) begin
      wrerr <= wrerr_d;
      lverr <= lverr_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_rsel)
      SEL_CTRL: begin
        bus_rdata[2:0]      = op;
        bus_rdata[CB_WREN]  = wren;
        bus_rdata[CB_LVERR] = lverr;
        bus_rdata[CB_WRERR] = wrerr;
        bus_rdata[CB_GO]    = busy;
      end
      SEL_TGT: bus_rdata = 32'(tgt);
      SEL_SRC: bus_rdata = 32'(src);
      SEL_KEY: bus_rdata = '0;
      default: bus_rdata = dat[bus_rsel[1:0]];
    endcase
  end
endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
  parameter int WI_W    = 6,
  parameter int PAGE_LW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              er_en,
  input  logic              er_all,
  input  logic [WI_W-1:0]   er_idx,
  input  logic              pg_en,
  input  logic [WI_W-1:0]   pg_base,
  input  logic [3:0]        pg_mask,
  input  logic [3:0][31:0]  pg_data,
  output logic              pg_clash,
  input  logic [WI_W-1:0]   rd_idx,
  output logic [31:0]       rd_data
);
  localparam int WORDS = 1 << WI_W;

  logic [31:0] cell_q [WORDS];
  logic [PAGE_LW-1:0] unused_er_low;

  assign unused_er_low = er_idx[PAGE_LW-1:0];
  assign rd_data = cell_q[rd_idx];

  always_comb begin
    pg_clash = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (pg_en && pg_mask[k] &&
          ((~cell_q[pg_base + WI_W'(k)] & pg_data[k]) != '0)) begin
        pg_clash = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
    end else if (er_en || pg_en) begin
      for (int i = 0; i < WORDS; i++) begin
        if (er_en && (er_all ||
            (WI_W'(i) >> PAGE_LW) == (er_idx >> PAGE_LW))) begin
          cell_q[i] <= '1;
        end else begin
          for (int k = 0; k < 4; k++) begin
            if (pg_en && pg_mask[k] && (pg_base + WI_W'(k) == WI_W'(i))) begin
              cell_q[i] <= cell_q[i] & pg_data[k];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/fpe_seq.sv
module fpe_seq
  import fpe_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_AW    = 16,
  parameter int ROW_LW    = 3,
  parameter int PROG_CYC  = 6,
  parameter int ROW_CYC   = 10,
  parameter int ERASE_CYC = 20,
  parameter int AREA_CYC  = 30,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              unlocked,
  input  logic              wren,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [MEM_AW-1:0] src,
  input  logic [3:0][31:0]  dat,
  input  logic [31:0]       mem_rdata,
  input  logic              lowv,
  input  logic              pg_clash,
  output logic              busy,
  output logic              clr_err,
  output logic              set_wrerr,
  output logic              set_lverr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              er_en,
  output logic              er_all,
  output logic [ADDR_W-3:0] er_idx,
  output logic              pg_en,
  output logic [ADDR_W-3:0] pg_base,
  output logic [3:0]        pg_mask,
  output logic [3:0][31:0]  pg_data
);
  localparam int WI_W      = ADDR_W - 2;
  localparam int ROW_WORDS = 1 << ROW_LW;

  sq_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, dur;
  logic [ROW_LW-1:0] idx_q, idx_d;
  logic [WI_W-1:0]   wi;
  logic              accept, go, reject, apply, fetch;
  logic [3:0]        unused_low;

  assign unused_low = {tgt[1:0], src[1:0]};
  assign wi     = tgt[ADDR_W-1:2];
  assign busy   = (st_q != SQ_IDLE);
  assign accept = start_wr && unlocked && !busy;
  assign go     = accept && wren && op_known(op);
  assign reject = accept && !(wren && op_known(op));
  assign apply  = (st_q == SQ_WAIT) && (cnt_q == '0);
  assign fetch  = (st_q == SQ_FETCH);

  always_comb begin
    case (op)
      OP_DWORD, OP_QWORD: dur = CNT_W'(PROG_CYC - 1);
      OP_PAGE_ER:         dur = CNT_W'(ERASE_CYC - 1);
      OP_AREA_ER:         dur = CNT_W'(AREA_CYC - 1);
      default:            dur = '0;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    case (st_q)
      SQ_IDLE: if (go) begin
        if (op == OP_ROW) begin
          st_d  = SQ_FETCH;
          idx_d = '0;
        end else begin
          st_d  = SQ_WAIT;
          cnt_d = dur;
        end
      end
      SQ_FETCH: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == ROW_LW'(ROW_WORDS - 1)) begin
          st_d  = SQ_WAIT;
          cnt_d = CNT_W'(ROW_CYC - 1);
        end
      end
      default: begin
        if (cnt_q == '0) st_d = SQ_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (go || busy) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign mem_addr = {src[MEM_AW-1:2] + (MEM_AW-2)'(idx_q), 2'b00};

  always_comb begin
    er_en   = apply && ((op == OP_PAGE_ER) || (op == OP_AREA_ER));
    er_all  = (op == OP_AREA_ER);
    er_idx  = wi;
    pg_data = dat;
    pg_en   = 1'b0;
    pg_base = '0;
    pg_mask = 4'b0000;
    if (fetch) begin
      pg_en      = 1'b1;
      pg_base    = {wi[WI_W-1:ROW_LW], idx_q};
      pg_mask    = 4'b0001;
      pg_data[0] = mem_rdata;
    end else if (apply && (op == OP_DWORD)) begin
      pg_en   = 1'b1;
      pg_base = {wi[WI_W-1:1], 1'b0};
      pg_mask = 4'b0011;
    end else if (apply && (op == OP_QWORD)) begin
      pg_en   = 1'b1;
      pg_base = {wi[WI_W-1:2], 2'b00};
      pg_mask = 4'b1111;
    end
  end

  assign clr_err   = go;
  assign set_wrerr = reject || (pg_en && pg_clash);
  assign set_lverr = busy && lowv;
endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
  import fpe_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_AW    = 16,
  parameter int ROW_LW    = 3,
  parameter int PAGE_LW   = 4,
  parameter int PROG_CYC  = 6,
  parameter int ROW_CYC   = 10,
  parameter int ERASE_CYC = 20,
  parameter int AREA_CYC  = 30,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_sel,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bus_rsel,
  output logic [31:0]       bus_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  input  logic              lowv_i,
  input  logic [ADDR_W-3:0] arr_ridx,
  output logic [31:0]       arr_rdata
);
  localparam int WI_W = ADDR_W - 2;

  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic              key_wr, other_wr, start_wr, unlocked;
  logic [2:0]        op;
  logic              wren, wrerr, lverr, busy;
  logic              clr_err, set_wrerr, set_lverr;
  logic [ADDR_W-1:0] tgt;
  logic [MEM_AW-1:0] src;
  logic [3:0][31:0]  dat;
  logic              er_en, er_all, pg_en, pg_clash;
  logic [WI_W-1:0]   er_idx, pg_base;
  logic [3:0]        pg_mask;
  logic [3:0][31:0]  pg_data;

  fpe_unlock u_unlock (
    .clk(clk), .rst_n(rst_q), .key_wr(key_wr), .key_data(bus_wdata),
    .other_wr(other_wr), .unlocked(unlocked)
  );

  fpe_regs #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_regs (
    .clk(clk), .rst_n(rst_q), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rsel(bus_rsel), .bus_rdata(bus_rdata),
    .busy(busy), .clr_err(clr_err), .set_wrerr(set_wrerr),
    .set_lverr(set_lverr), .key_wr(key_wr), .other_wr(other_wr),
    .start_wr(start_wr), .op(op), .wren(wren), .wrerr(wrerr),
    .lverr(lverr), .tgt(tgt), .src(src), .dat(dat)
  );

  fpe_seq #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .ROW_LW(ROW_LW),
    .PROG_CYC(PROG_CYC), .ROW_CYC(ROW_CYC), .ERASE_CYC(ERASE_CYC),
    .AREA_CYC(AREA_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_q), .start_wr(start_wr), .unlocked(unlocked),
    .wren(wren), .op(op), .tgt(tgt), .src(src), .dat(dat),
    .mem_rdata(mem_rdata), .lowv(lowv_i), .pg_clash(pg_clash),
    .busy(busy), .clr_err(clr_err), .set_wrerr(set_wrerr),
    .set_lverr(set_lverr), .mem_addr(mem_addr), .er_en(er_en),
    .er_all(er_all), .er_idx(er_idx), .pg_en(pg_en), .pg_base(pg_base),
    .pg_mask(pg_mask), .pg_data(pg_data)
  );

  fpe_array #(.WI_W(WI_W), .PAGE_LW(PAGE_LW)) u_array (
    .clk(clk), .rst_n(rst_q), .er_en(er_en), .er_all(er_all),
    .er_idx(er_idx), .pg_en(pg_en), .pg_base(pg_base), .pg_mask(pg_mask),
    .pg_data(pg_data), .pg_clash(pg_clash), .rd_idx(arr_ridx),
    .rd_data(arr_rdata)
  );
endmodule

// File: rtl/fpe_ctrl_chk.sv
module fpe_ctrl_chk
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LIMIT  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [2:0]        bus_sel,
  input logic              start_wr,
  input logic              unlocked,
  input logic              wren,
  input logic              busy,
  input logic              wrerr,
  input logic [ADDR_W-1:0] tgt
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr && unlocked && wren)); // R1
  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !unlocked && !busy) |=> !busy); // R2
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel != SEL_KEY) |=> !unlocked); // R2
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && unlocked && !busy && !wren) |=> (wrerr && !busy)); // R3
  AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_sel == SEL_TGT) |=> $stable(tgt)); // R10
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 16'(LIMIT)); // R4
endmodule

bind fpe_ctrl fpe_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .LIMIT((1 << ROW_LW) + ROW_CYC + PROG_CYC + ERASE_CYC + AREA_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_q), .bus_we(bus_we), .bus_sel(bus_sel),
  .start_wr(start_wr), .unlocked(unlocked), .wren(wren), .busy(busy),
  .wrerr(wrerr), .tgt(tgt)
);

// File: tb/fpe_ctrl_bench.sv
`timescale 1ns/1ps
module fpe_ctrl_bench;
  localparam int PROG_CYC = 6, ROW_CYC = 10, ERASE_CYC = 20, AREA_CYC = 30;
  localparam int ROW_WORDS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_sel, bus_rsel;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        lowv_i;
  logic [5:0]  arr_ridx;
  logic [31:0] arr_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign mem_rdata = {mem_addr, ~mem_addr};

  fpe_ctrl u_fpe_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rsel(bus_rsel), .bus_rdata(bus_rdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .lowv_i(lowv_i),
    .arr_ridx(arr_ridx), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    bus_rsel = s; #0.1; v = bus_rdata;
  endtask

  task automatic arr(input int i, output logic [31:0] v);
    arr_ridx = 6'(i); #0.1; v = arr_rdata;
  endtask

  task automatic keys_start();
    wr(1, 32'h0); wr(1, 32'hAA996655); wr(1, 32'h556699AA); wr(0, 32'h8000);
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(0, v);
    while (v[15] && n < 5000) begin
      n++; @(negedge clk); rd(0, v);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input int exp_n, input string rq);
    int n;
    wr(0, 32'h0 | 32'(op));
    wr(0, 32'h10 | 32'(op));
    keys_start();
    wait_idle(n);
    chk(n == exp_n, rq, 32'(n), 32'(exp_n));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk(v == 0, "R12 ctrl", v, 0);
    arr(0, v); chk(v == '1, "R12 word0", v, '1);
    arr(63, v); chk(v == '1, "R12 word63", v, '1);
  endtask

  task automatic t_dword();
    logic [31:0] v;
    wr(2, 32'h0C); wr(4, 32'hFFFF0000); wr(5, 32'h12345678);
    run_op(3'd1, PROG_CYC, "R4 R1 dword busy");
    arr(2, v); chk(v == 32'hFFFF0000, "R5 word2", v, 32'hFFFF0000);
    arr(3, v); chk(v == 32'h12345678, "R5 word3", v, 32'h12345678);
    arr(4, v); chk(v == '1, "R5 word4", v, '1);
    rd(0, v); chk(v[13] == 0, "R9 no clash", v, 0);
  endtask

  task automatic t_qword();
    logic [31:0] v;
    wr(2, 32'h24);
    for (int k = 0; k < 4; k++) wr(3'(4 + k), 32'hA0000000 + 32'(k));
    run_op(3'd2, PROG_CYC, "R4 qword busy");
    for (int k = 0; k < 4; k++) begin
      arr(8 + k, v);
      chk(v == 32'hA0000000 + 32'(k), "R6 quad word", v, 32'hA0000000 + 32'(k));
    end
  endtask

  task automatic t_clash();
    logic [31:0] v;
    wr(2, 32'h08); wr(4, 32'h0000FFFF); wr(5, 32'hFFFFFFFF);
    run_op(3'd1, PROG_CYC, "R4 clash busy");
    arr(2, v); chk(v == 0, "R9 and-store", v, 0);
    arr(3, v); chk(v == 32'h12345678, "R9 and-store hi", v, 32'h12345678);
    rd(0, v); chk(v[13] == 1, "R9 wrerr", v[13], 1);
  endtask

  task automatic t_row();
    logic [31:0] v;
    wr(3, 32'h100); wr(2, 32'h44);
    run_op(3'd3, ROW_WORDS + ROW_CYC, "R4 row busy");
    for (int i = 0; i < ROW_WORDS; i++) begin
      arr(16 + i, v);
      chk(v == memf(16'(32'h100 + 4 * i)), "R7 row word", v, memf(16'(32'h100 + 4 * i)));
    end
    rd(0, v); chk(v[13] == 0, "R11 clear at start", v[13], 0);
  endtask

  task automatic t_page();
    logic [31:0] v;
    wr(2, 32'h40);
    run_op(3'd4, ERASE_CYC, "R4 page busy");
    arr(16, v); chk(v == '1, "R8 page word16", v, '1);
    arr(23, v); chk(v == '1, "R8 page word23", v, '1);
    arr(8, v); chk(v == 32'hA0000000, "R8 other page", v, 32'hA0000000);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wr(2, 32'hA0); wr(4, 32'h0); wr(5, 32'h0);
    wr(0, 32'h11);
    wr(1, 32'h0); wr(1, 32'h1234); wr(1, 32'h556699AA); wr(0, 32'h8000);
    rd(0, v); chk(v[15] == 0 && v[13] == 0, "R2 bad key", v, 32'h11);
    wr(1, 32'h0); wr(1, 32'hAA996655); wr(1, 32'h556699AA);
    wr(4, 32'h0); wr(0, 32'h8000);
    rd(0, v); chk(v[15] == 0 && v[13] == 0, "R2 intervening", v, 32'h11);
    repeat (PROG_CYC + 2) @(negedge clk);
    arr(40, v); chk(v == '1, "R2 array kept", v, '1);
  endtask

  task automatic t_reject();
    logic [31:0] v;
    wr(0, 32'h01); keys_start();
    rd(0, v); chk(v[15] == 0 && v[13] == 1, "R3 wren low", v, 32'h2001);
    wr(0, 32'h15); keys_start();
    rd(0, v); chk(v[15] == 0 && v[13] == 1, "R3 bad op", v, 32'h2015);
    repeat (PROG_CYC + 2) @(negedge clk);
    arr(40, v); chk(v == '1, "R3 array kept", v, '1);
  endtask

  task automatic t_blocked();
    logic [31:0] v;
    int n;
    wr(2, 32'h80); wr(0, 32'h14); keys_start();
    lowv_i = 1'b1; wr(2, 32'h04); lowv_i = 1'b0;
    wr(4, 32'h5555); wr(3, 32'h200); wr(0, 32'h11);
    wait_idle(n);
    rd(2, v); chk(v == 32'h80, "R10 tgt held", v, 32'h80);
    rd(4, v); chk(v == 32'h0, "R10 data held", v, 0);
    rd(3, v); chk(v == 32'h100, "R10 src held", v, 32'h100);
    rd(0, v); chk(v[4:0] == 5'h14, "R10 ctrl held", v[4:0], 32'h14);
    chk(v[12] == 1, "R11 lverr set", v[12], 1);
    wr(0, 32'h14);
    rd(0, v); chk(v[12] == 0, "R11 plain clear", v[12], 0);
  endtask

  task automatic t_area();
    logic [31:0] v;
    run_op(3'd0, 1, "R4 nop busy");
    run_op(3'd7, AREA_CYC, "R4 area busy");
    arr(3, v); chk(v == '1, "R8 area word3", v, '1);
    arr(9, v); chk(v == '1, "R8 area word9", v, '1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = '0; bus_wdata = '0;
    bus_rsel = '0; lowv_i = 1'b0; arr_ridx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dword();
    t_qword();
    t_clash();
    t_row();
    t_page();
    t_locked();
    t_reject();
    t_blocked();
    t_area();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule